// File: doc/BRIEF.md
# Target Read Latency and Retry Controller

This block decides, cycle by cycle, how a bus target answers a read (memory or I/O) or an I/O write whose read data comes from a FIFO filled by the application. A transaction opens with a one-cycle `req_start` carrying command, address and write data. Until it closes, the block drives exactly one of four responses in each cycle: wait, data beat, retry or disconnect.

Two modes govern the first beat. In deferred mode, a new request is refused with a retry, and its address, command and write data are held in a single pending slot. The application reads the slot and prepares the data, and the access completes when the master comes back with the same address and command. In direct mode, the block holds the master with wait states until the FIFO has data, and gives a retry once a selectable first-beat budget runs out. After the first beat, a separate hold-off control chooses between disconnecting at once when the FIFO runs dry and waiting a bounded number of cycles for more data.

Top module: `tgt_rd_ctrl`

## Requirements
- R1: In deferred mode (`dly_mode_n`=0, sampled at `req_start`), a read or I/O write that finds the pending slot empty gets `t_retry` in its first cycle. Its address, command and write data appear on `pend_addr`, `pend_cmd` and `pend_wdata`, with `pend_valid`=1, from the next cycle.
- R2: In deferred mode, a request whose address and command equal the pending slot completes in its first cycle. For a read, `t_data` is given if `fifo_empty`=0 and `t_retry` if it is 1, with no wait states. For an I/O write, `t_data` is given regardless of the FIFO.
- R3: In direct mode, a read drives `t_wait` while `fifo_empty`=1 and gives `t_data` in the first cycle the FIFO is not empty. This includes the cycle in which the budget is reached, where data takes priority over retry.
- R4: In direct mode, a read that sees an empty FIFO for the whole first-beat budget gets `t_wait` for exactly L cycles and then `t_retry`. L is 16 when `lat_sel`=0 and 32 when `lat_sel`=1, sampled at `req_start`. The count restarts for every transaction.
- R5: After a beat has moved, if `burst_pend_n`=1 and the FIFO is empty, the block gives `t_disc` in that cycle and the transaction ends.
- R6: After a beat has moved, if `burst_pend_n`=0 and the FIFO is empty, the block inserts at most 8 `t_wait` cycles. It gives `t_disc` on the next cycle if the FIFO is still empty, and resumes `t_data` as soon as the FIFO has data.
- R7: `burst_pend_n` must stay constant throughout a transaction.
- R8: In deferred mode, a request whose address or command differs from a filled pending slot gets `t_retry`, and the slot keeps its contents.
- R9: The pending slot empties (`pend_valid`=0) when a matching transaction ends after moving data, and on reset.
- R10: Command codes: reads are 0010, 0110, 1100 and 1110, and the I/O write is 0011. An I/O write is always a single beat, and in direct mode it gets `t_data` in its first cycle. Any other command at `req_start` produces no response and leaves the slot unchanged.
- R11: A read beat with `mst_last`=1 ends the transaction. Otherwise the burst continues.
- R12: While a transaction is open, exactly one of `t_wait`, `t_data`, `t_retry` and `t_disc` is high in each cycle. When no transaction is open, none of them is high, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Address phase of a new transaction (one cycle, only when idle) |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | I/O write data |
| mst_last | input | 1 | Master takes no further beat after the current one |
| dly_mode_n | input | 1 | Deferred mode, active low |
| lat_sel | input | 1 | First-beat budget: 0 selects 16 cycles, 1 selects 32 cycles |
| burst_pend_n | input | 1 | Hold off for later beats, active low |
| fifo_empty | input | 1 | Read data FIFO is empty |
| t_wait | output | 1 | Wait state this cycle |
| t_data | output | 1 | Data beat moves this cycle (pops the FIFO on reads) |
| t_retry | output | 1 | Retry, transaction ends |
| t_disc | output | 1 | Disconnect without data, transaction ends |
| pend_valid | output | 1 | Pending slot is filled |
| pend_addr | output | AW | Pending address |
| pend_cmd | output | 4 | Pending command |
| pend_wdata | output | DW | Pending I/O write data |

## Verification
The hardest state to reach from the ports is a filled pending slot that is then presented with near-miss requests: same address but another command, another address, and an exact match while the FIFO is still empty. Each of these must retry and leave the slot intact, and only the matching request with data present may drain it. The stimulus builds this state by issuing one deferred read, then replaying variants of it while the FIFO flag is held, and reading the slot back through the pending outputs after each attempt. The exact budget edges (data arriving on the last wait count, and the eighth hold-off wait) are reached by holding the FIFO empty for counted cycles.

// File: rtl/tgt_rd_pkg.sv
// Shared types and command decoding for the target read latency controller.
// Assumes the standard 4-bit bus command encoding.
package tgt_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_BURST = 2'd2
    } tr_state_e;

    localparam logic [3:0] CMD_IO_RD       = 4'b0010;
    localparam logic [3:0] CMD_IO_WR       = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

    function automatic logic cmd_is_read(input logic [3:0] c);
        return (c == CMD_IO_RD) || (c == CMD_MEM_RD) ||
               (c == CMD_MEM_RD_MULT) || (c == CMD_MEM_RD_LINE);
    endfunction

    function automatic logic cmd_is_iowr(input logic [3:0] c);
        return c == CMD_IO_WR;
    endfunction

endpackage

// File: rtl/tgt_rd_lat_cnt.sv
// Saturation-free cycle counter used for wait-state budgets.
// Assumes the controller clears it before it can reach all-ones.
module tgt_rd_lat_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count waited cycles, restart on request.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clr)   count <= '0;
        else if (inc)   count <= count + 1'b1;
    end

    // R4
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !clr |-> count != '1);

endmodule

// File: rtl/tgt_rd_entry.sv
// Single pending-request slot for deferred transactions, with match logic.
// Assumes store is only requested while the slot is empty.
module tgt_rd_entry #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store_en,
    input  logic          clear_en,
    input  logic [AW-1:0] in_addr,
    input  logic [3:0]    in_cmd,
    input  logic [DW-1:0] in_wdata,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic [3:0]    cmd,
    output logic [DW-1:0] wdata,
    output logic          hit
);

    // Fill the slot on store, empty it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            cmd   <= '0;
            wdata <= '0;
        end else if (clear_en) begin
            valid <= 1'b0;
        end else if (store_en) begin
            valid <= 1'b1;
            addr  <= in_addr;
            cmd   <= in_cmd;
            wdata <= in_wdata;
        end
    end

    // Compare the open request against the slot.
    always_comb hit = valid && (addr == in_addr) && (cmd == in_cmd);

    // R8
    entry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !store_en);

    // R9
    entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_en |=> !valid);

    // R9
    entry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_en && clear_en));

endmodule

// File: rtl/tgt_rd_fsm.sv
// Response sequencer: walks first-beat and later-beat phases and picks one
// of wait/data/retry/disconnect per cycle.
// Assumes req_start arrives only while idle and burst_pend_n is static per transaction.
module tgt_rd_fsm
    import tgt_rd_pkg::*;
#(
    parameter int INIT_LAT_SHORT = 16,
    parameter int INIT_LAT_LONG  = 32,
    parameter int SUB_LAT        = 8,
    localparam int ICW = $clog2(INIT_LAT_LONG + 2),
    localparam int SCW = $clog2(SUB_LAT + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_start,
    input  logic [3:0]     req_cmd,
    input  logic           dly_mode_n,
    input  logic           lat_sel,
    input  logic           burst_pend_n,
    input  logic           fifo_empty,
    input  logic           mst_last,
    input  logic           ent_valid,
    input  logic           ent_hit,
    input  logic [ICW-1:0] icnt,
    input  logic [SCW-1:0] scnt,
    output logic           cap_en,
    output logic           ent_store,
    output logic           ent_clear,
    output logic           icnt_clr,
    output logic           icnt_inc,
    output logic           scnt_clr,
    output logic           scnt_inc,
    output logic           t_wait,
    output logic           t_data,
    output logic           t_retry,
    output logic           t_disc
);

    localparam logic [ICW-1:0] LIM_SHORT = ICW'(INIT_LAT_SHORT);
    localparam logic [ICW-1:0] LIM_LONG  = ICW'(INIT_LAT_LONG);
    localparam logic [SCW-1:0] LIM_SUB   = SCW'(SUB_LAT);

    tr_state_e state, state_nx;
    logic      cur_dly, cur_long, cur_rd;
    logic [ICW-1:0] lim;

    // Accept a read or I/O write at the address phase.
    always_comb cap_en = (state == ST_IDLE) && req_start &&
                         (cmd_is_read(req_cmd) || cmd_is_iowr(req_cmd));

    // Latch the mode and budget chosen for this transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_dly  <= 1'b0;
            cur_long <= 1'b0;
            cur_rd   <= 1'b0;
        end else if (cap_en) begin
            cur_dly  <= !dly_mode_n;
            cur_long <= lat_sel;
            cur_rd   <= cmd_is_read(req_cmd);
        end
    end

    always_comb lim = cur_long ? LIM_LONG : LIM_SHORT;

    // Choose this cycle's response and the next phase.
    always_comb begin
        state_nx  = state;
        t_wait    = 1'b0;
        t_data    = 1'b0;
        t_retry   = 1'b0;
        t_disc    = 1'b0;
        ent_store = 1'b0;
        ent_clear = 1'b0;
        icnt_clr  = cap_en;
        icnt_inc  = 1'b0;
        scnt_clr  = 1'b0;
        scnt_inc  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cap_en) state_nx = ST_FIRST;
            end
            ST_FIRST: begin
                if (cur_dly) begin
                    if (ent_hit) begin
                        if (!cur_rd || !fifo_empty) t_data  = 1'b1;
                        else                        t_retry = 1'b1;
                    end else begin
                        t_retry   = 1'b1;
                        ent_store = !ent_valid;
                    end
                end else begin
                    if (!cur_rd || !fifo_empty) t_data   = 1'b1;
                    else if (icnt == lim)        t_retry  = 1'b1;
                    else begin
                        t_wait   = 1'b1;
                        icnt_inc = 1'b1;
                    end
                end
                if (t_retry) state_nx = ST_IDLE;
                if (t_data) begin
                    if (mst_last || !cur_rd) begin
                        state_nx  = ST_IDLE;
                        ent_clear = cur_dly && ent_hit;
                    end else begin
                        state_nx = ST_BURST;
                        scnt_clr = 1'b1;
                    end
                end
            end
            ST_BURST: begin
                if (!fifo_empty) begin
                    t_data   = 1'b1;
                    scnt_clr = 1'b1;
                    if (mst_last) begin
                        state_nx  = ST_IDLE;
                        ent_clear = cur_dly && ent_hit;
                    end
                end else if (burst_pend_n || scnt == LIM_SUB) begin
                    t_disc    = 1'b1;
                    state_nx  = ST_IDLE;
                    ent_clear = cur_dly && ent_hit;
                end else begin
                    t_wait   = 1'b1;
                    scnt_inc = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R12
    one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({t_wait, t_data, t_retry, t_disc}) == ((state != ST_IDLE) ? 1 : 0));

    // R1
    dly_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST) && cur_dly |-> !t_wait);

    // R5
    burst_nohold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST) && fifo_empty && burst_pend_n |-> t_disc);

    // R6
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST) && t_wait |-> !burst_pend_n);

    // R7
    bp_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && ($past(state) != ST_IDLE) |-> $stable(burst_pend_n));

    // R4
    lim_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST) && !cur_dly && t_retry |-> $past(t_wait));

endmodule

// File: rtl/tgt_rd_ctrl.sv
// Top of the target read latency and retry controller: holds the open
// request, the deferred-request slot, the two wait budgets and the sequencer.
// Assumes one transaction at a time and a FIFO-empty flag valid every cycle.
module tgt_rd_ctrl #(
    parameter int AW             = 32,
    parameter int DW             = 32,
    parameter int INIT_LAT_SHORT = 16,
    parameter int INIT_LAT_LONG  = 32,
    parameter int SUB_LAT        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic [3:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          mst_last,
    input  logic          dly_mode_n,
    input  logic          lat_sel,
    input  logic          burst_pend_n,
    input  logic          fifo_empty,
    output logic          t_wait,
    output logic          t_data,
    output logic          t_retry,
    output logic          t_disc,
    output logic          pend_valid,
    output logic [AW-1:0] pend_addr,
    output logic [3:0]    pend_cmd,
    output logic [DW-1:0] pend_wdata
);

    localparam int ICW = $clog2(INIT_LAT_LONG + 2);
    localparam int SCW = $clog2(SUB_LAT + 2);

    logic          cap_en, ent_store, ent_clear, ent_hit;
    logic          icnt_clr, icnt_inc, scnt_clr, scnt_inc;
    logic [ICW-1:0] icnt;
    logic [SCW-1:0] scnt;
    logic [AW-1:0] cur_addr;
    logic [3:0]    cur_cmd;
    logic [DW-1:0] cur_wdata;

    // Hold the open request's address, command and write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_cmd   <= '0;
            cur_wdata <= '0;
        end else if (cap_en) begin
            cur_addr  <= req_addr;
            cur_cmd   <= req_cmd;
            cur_wdata <= req_wdata;
        end
    end

    tgt_rd_entry #(.AW(AW), .DW(DW)) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .store_en (ent_store),
        .clear_en (ent_clear),
        .in_addr  (cur_addr),
        .in_cmd   (cur_cmd),
        .in_wdata (cur_wdata),
        .valid    (pend_valid),
        .addr     (pend_addr),
        .cmd      (pend_cmd),
        .wdata    (pend_wdata),
        .hit      (ent_hit)
    );

    tgt_rd_lat_cnt #(.W(ICW)) u_icnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (icnt_clr),
        .inc   (icnt_inc),
        .count (icnt)
    );

    tgt_rd_lat_cnt #(.W(SCW)) u_scnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (scnt_clr),
        .inc   (scnt_inc),
        .count (scnt)
    );

    tgt_rd_fsm #(
        .INIT_LAT_SHORT (INIT_LAT_SHORT),
        .INIT_LAT_LONG  (INIT_LAT_LONG),
        .SUB_LAT        (SUB_LAT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_start    (req_start),
        .req_cmd      (req_cmd),
        .dly_mode_n   (dly_mode_n),
        .lat_sel      (lat_sel),
        .burst_pend_n (burst_pend_n),
        .fifo_empty   (fifo_empty),
        .mst_last     (mst_last),
        .ent_valid    (pend_valid),
        .ent_hit      (ent_hit),
        .icnt         (icnt),
        .scnt         (scnt),
        .cap_en       (cap_en),
        .ent_store    (ent_store),
        .ent_clear    (ent_clear),
        .icnt_clr     (icnt_clr),
        .icnt_inc     (icnt_inc),
        .scnt_clr     (scnt_clr),
        .scnt_inc     (scnt_inc),
        .t_wait       (t_wait),
        .t_data       (t_data),
        .t_retry      (t_retry),
        .t_disc       (t_disc)
    );

endmodule

// File: tb/tgt_rd_ctrl_bench.sv
// Scoreboard bench: a driver queues per-cycle expected responses with their
// FIFO/last stimulus, a monitor pops and compares every non-idle response.
module tgt_rd_ctrl_bench;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int C_W = 1, C_D = 2, C_R = 3, C_X = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic [3:0]    req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          mst_last = 1'b0;
    logic          dly_mode_n = 1'b1;
    logic          lat_sel = 1'b0;
    logic          burst_pend_n = 1'b1;
    logic          fifo_empty = 1'b1;
    logic          t_wait, t_data, t_retry, t_disc;
    logic          pend_valid;
    logic [AW-1:0] pend_addr;
    logic [3:0]    pend_cmd;
    logic [DW-1:0] pend_wdata;

    int vectors = 0;
    int misses = 0;
    bit finished = 1'b0;

    int    exp_q[$];
    string tag_q[$];
    bit    fe_q[$];
    bit    last_q[$];
    string cur_tag = "R12";

    always #5 clk = ~clk;

    tgt_rd_ctrl u_tgt_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .mst_last(mst_last),
        .dly_mode_n(dly_mode_n), .lat_sel(lat_sel), .burst_pend_n(burst_pend_n),
        .fifo_empty(fifo_empty), .t_wait(t_wait), .t_data(t_data),
        .t_retry(t_retry), .t_disc(t_disc), .pend_valid(pend_valid),
        .pend_addr(pend_addr), .pend_cmd(pend_cmd), .pend_wdata(pend_wdata)
    );

    task automatic check(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Queue one expected cycle with the stimulus that goes with it.
    task automatic step(input int code, input bit fe, input bit last);
        exp_q.push_back(code);
        tag_q.push_back(cur_tag);
        fe_q.push_back(fe);
        last_q.push_back(last);
    endtask

    // Drive one transaction and play back the queued stimulus.
    task automatic run(input logic [3:0] cmd, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input bit dly_n,
                       input bit bp_n, input bit lsel);
        @(posedge clk); #1;
        req_cmd = cmd; req_addr = a; req_wdata = wd;
        dly_mode_n = dly_n; burst_pend_n = bp_n; lat_sel = lsel;
        req_start = 1'b1;
        @(posedge clk); #1;
        req_start = 1'b0;
        while (fe_q.size() > 0) begin
            fifo_empty = fe_q.pop_front();
            mst_last   = last_q.pop_front();
            @(posedge clk); #1;
        end
        fifo_empty = 1'b1; mst_last = 1'b0;
        @(posedge clk); #1;
        check({cur_tag, " all expected responses seen"}, exp_q.size(), 0);
        exp_q.delete(); tag_q.delete();
    endtask

    // Monitor: pop and compare every cycle the design responds.
    always @(negedge clk) begin
        if (rst_n) begin
            int code;
            case ({t_wait, t_data, t_retry, t_disc})
                4'b0000: code = 0;
                4'b1000: code = C_W;
                4'b0100: code = C_D;
                4'b0010: code = C_R;
                4'b0001: code = C_X;
                default: code = 9;
            endcase
            if (code != 0) begin
                if (exp_q.size() == 0) check("R12 unexpected response", code, 0);
                else check(tag_q.pop_front(), code, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: idle outputs after reset; R9: slot empty
        check("R12 idle after reset", {t_wait, t_data, t_retry, t_disc}, 0);
        check("R9 slot empty after reset", pend_valid, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R3/R11: direct read, 3 empty cycles then a 4-beat burst
        cur_tag = "R3";
        repeat (3) step(C_W, 1, 0);
        step(C_D, 0, 0); step(C_D, 0, 0); step(C_D, 0, 0);
        cur_tag = "R11"; step(C_D, 0, 1);
        run(4'b0110, 32'h100, 0, 1, 1, 0);

        // R4: 16-cycle budget runs out
        cur_tag = "R4";
        repeat (16) step(C_W, 1, 0);
        step(C_R, 1, 0);
        run(4'b0010, 32'h104, 0, 1, 1, 0);

        // R4: 32-cycle budget runs out, counter restarted
        repeat (32) step(C_W, 1, 0);
        step(C_R, 1, 0);
        run(4'b1100, 32'h108, 0, 1, 1, 1);

        // R3: data on the limit cycle wins over retry
        cur_tag = "R3";
        repeat (16) step(C_W, 1, 0);
        step(C_D, 0, 1);
        run(4'b0110, 32'h10C, 0, 1, 1, 0);

        // R5: no hold-off, FIFO runs dry after one beat
        cur_tag = "R5";
        step(C_D, 0, 0); step(C_X, 1, 0);
        run(4'b1110, 32'h110, 0, 1, 1, 0);

        // R6: hold-off, data returns after 3 waits
        cur_tag = "R6";
        step(C_D, 0, 0); repeat (3) step(C_W, 1, 0); step(C_D, 0, 1);
        run(4'b0110, 32'h114, 0, 1, 0, 0);

        // R6: hold-off exhausted after 8 waits
        step(C_D, 0, 0); repeat (8) step(C_W, 1, 0); step(C_X, 1, 0);
        run(4'b0110, 32'h118, 0, 1, 0, 0);

        // R1: deferred read with empty slot, retry even though data is present
        cur_tag = "R1";
        step(C_R, 0, 0);
        run(4'b0110, 32'hA000, 0, 0, 1, 0);
        check("R1 slot filled", pend_valid, 1);
        check("R1 slot address", pend_addr, 32'hA000);
        check("R1 slot command", pend_cmd, 4'b0110);

        // R8: different address retries, slot kept
        cur_tag = "R8";
        step(C_R, 0, 0);
        run(4'b0110, 32'hB000, 0, 0, 1, 0);
        check("R8 slot address kept", pend_addr, 32'hA000);
        check("R8 slot still filled", pend_valid, 1);

        // R8: same address, other command retries, slot kept
        step(C_R, 0, 0);
        run(4'b0010, 32'hA000, 0, 0, 1, 0);
        check("R8 slot command kept", pend_cmd, 4'b0110);

        // R10: ignored command gives no response, slot kept
        cur_tag = "R10";
        run(4'b0111, 32'hA000, 0, 0, 1, 0);
        check("R10 slot unchanged", pend_valid, 1);
        check("R10 slot address unchanged", pend_addr, 32'hA000);

        // R2: match but FIFO empty retries at once, slot kept
        cur_tag = "R2";
        step(C_R, 1, 0);
        run(4'b0110, 32'hA000, 0, 0, 1, 0);
        check("R2 slot kept on empty match", pend_valid, 1);

        // R2/R9: match with data completes a 2-beat burst and drains the slot
        step(C_D, 0, 0); step(C_D, 0, 1);
        run(4'b0110, 32'hA000, 0, 0, 1, 0);
        check("R9 slot drained after data", pend_valid, 0);

        // R1: deferred I/O write stores its data
        cur_tag = "R1";
        step(C_R, 1, 0);
        run(4'b0011, 32'hC000, 32'hDEAD_BEEF, 0, 1, 0);
        check("R1 slot write data", pend_wdata, 32'hDEAD_BEEF);

        // R2/R10: repeated I/O write completes as one beat despite empty FIFO
        cur_tag = "R2";
        step(C_D, 1, 0);
        run(4'b0011, 32'hC000, 32'h0, 0, 1, 0);
        check("R9 slot drained after write", pend_valid, 0);

        // R10: direct I/O write completes in its first cycle
        cur_tag = "R10";
        step(C_D, 1, 0);
        run(4'b0011, 32'hC004, 32'h1, 1, 1, 0);

        // R9: reset empties a filled slot
        cur_tag = "R9";
        step(C_R, 1, 0);
        run(4'b0010, 32'hD000, 0, 0, 1, 0);
        check("R9 slot filled before reset", pend_valid, 1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        check("R9 slot empty after reset", pend_valid, 0);
        @(posedge clk); #1;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule